// File: doc/BRIEF.md
# Row-register cached DRAM controller

This block models a DRAM array with one row-wide register placed in front of it. A comparator checks the row field of each access against the row that the register holds. Reads are always served out of the register. A read hit returns its word one clock after it is accepted. A read miss first copies the addressed array row into the register and then returns the word from there, three clocks after acceptance by default.

Writes are posted. They finish at hit latency and always go into the array. When a write targets the row that the register holds, the register word is patched in the same clock, so the register and the array stay coherent. A write to any other row leaves the register alone.

A background refresh counter steps through the array rows and raises one refresh strobe per programmable interval. Reads from the register never wait for a refresh. A refresh that falls due while the array is busy with a miss load or a write is held back until the array is free.

Top module: `rowreg_dram`

## Requirements
- R1: After reset, `ready_o`, `ref_stb_o` and `rdata_o` are low and the row register is invalid, so the first read takes the miss latency (`MISS_LAT`, 3 clocks).
- R2: An access is accepted on a clock edge where `req_i` is high and `ready_o` is low. The row is `addr_i[ADDR_W-1:COL_W]` and the column is `addr_i[COL_W-1:0]`. A read whose row equals the valid held row raises `ready_o` for one cycle, one clock after acceptance, with the stored word on `rdata_o`.
- R3: A read miss raises `ready_o` exactly `MISS_LAT` clocks after acceptance, with the addressed word, and the addressed row becomes the held row.
- R4: Reads that follow a miss and stay in the newly loaded row complete at the one-clock hit latency.
- R5: A write raises `ready_o` one clock after acceptance, whether or not it hits, and its data is returned by any later read of that address.
- R6: A write to the held row also updates the row register, so a following read of that address hits and returns the new data.
- R7: A write to a row other than the held one loads nothing into the register: a following read of the held row still hits, and a read of the written row misses.
- R8: With no accesses, `ref_stb_o` pulses for one cycle every `REF_INT` clocks. Successive strobes report rows 0, 1, 2, ... on `ref_row_o`, wrapping from the last row back to 0.
- R9: No refresh strobe is issued on a clock edge at which the array is busy. The array is busy on the edge that accepts a write, on the edge that accepts a read miss, and on the edges of the following miss load. A refresh due at such a time is issued later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address, row in the upper bits |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read data, valid with `ready_o` on reads |
| ref_stb_o | output | 1 | One-cycle refresh strobe |
| ref_row_o | output | ROW_W | Row refreshed by the current strobe |

## Verification
The assertions assume that `req_i`, `we_i`, `addr_i` and `wdata_i` stay stable from the request until `ready_o`, and that a new request is only presented after the previous one has completed. They also assume `REF_INT` is larger than the miss latency, so that a deferred refresh is issued before the next one falls due. The stimulus raises each request after a rising edge and holds it until it sees the completion pulse. It drops the request or changes it only after the edge on which `ready_o` was high. The bench keeps its own model of the held row, so it knows in advance which cycles keep the array busy and which latency to expect.

// File: rtl/rowreg_pkg.sv
package rowreg_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_LOAD} rr_state_e;
endpackage

// File: rtl/rowreg_array.sv
module rowreg_array #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ROW_W-1:0]              wr_row_i,
  input  logic [COL_W-1:0]              wr_col_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [ROW_W-1:0]              rd_row_i,
  output logic [(1<<COL_W)*DATA_W-1:0]  rd_line_o
);
  localparam int NUM_ROWS = 1 << ROW_W;
  localparam int NUM_COLS = 1 << COL_W;

  logic [DATA_W-1:0] mem_q [NUM_ROWS][NUM_COLS];

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[r][c] <= '0;
        else if (we_i && wr_row_i == ROW_W'(r) && wr_col_i == COL_W'(c))
          mem_q[r][c] <= wr_data_i;
      end
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_rd
    assign rd_line_o[c*DATA_W +: DATA_W] = mem_q[rd_row_i][c];
  end
endmodule

// File: rtl/rowreg_line.sv
module rowreg_line #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [ROW_W-1:0]              load_row_i,
  input  logic [(1<<COL_W)*DATA_W-1:0]  load_line_i,
  input  logic                          patch_i,
  input  logic [COL_W-1:0]              patch_col_i,
  input  logic [DATA_W-1:0]             patch_data_i,
  input  logic [ROW_W-1:0]              cmp_row_i,
  input  logic [COL_W-1:0]              sel_col_i,
  output logic                          hit_o,
  output logic [DATA_W-1:0]             word_o,
  output logic [ROW_W-1:0]              tag_o,
  output logic                          valid_o
);
  localparam int NUM_COLS = 1 << COL_W;

  logic [DATA_W-1:0] line_q [NUM_COLS];
  logic [ROW_W-1:0]  tag_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      tag_q   <= load_row_i;
      valid_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line_q[c] <= '0;
      else if (load_i) line_q[c] <= load_line_i[c*DATA_W +: DATA_W];
      else if (patch_i && patch_col_i == COL_W'(c)) line_q[c] <= patch_data_i;
    end
  end

  assign hit_o   = valid_q && (tag_q == cmp_row_i);
  assign word_o  = line_q[sel_col_i];
  assign tag_o   = tag_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/rowreg_refresh.sv
module rowreg_refresh #(
  parameter int ROW_W   = 3,
  parameter int REF_INT = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  output logic             stb_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int IW = (REF_INT > 2) ? $clog2(REF_INT) : 1;

  logic [IW-1:0]    tick_q;
  logic             tick, pend_q, issue;
  logic [ROW_W-1:0] ptr_q;

  assign tick  = (tick_q == IW'(REF_INT - 1));
  assign issue = pend_q && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      pend_q <= 1'b0;
      ptr_q  <= '0;
      stb_o  <= 1'b0;
      row_o  <= '0;
    end else begin
      tick_q <= tick ? '0 : tick_q + 1'b1;
      pend_q <= (pend_q && !issue) || tick;
      stb_o  <= issue;
      if (issue) begin
        row_o <= ptr_q;
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rowreg_dram.sv
module rowreg_dram
  import rowreg_pkg::*;
#(
  parameter int ROW_W    = 3,
  parameter int COL_W    = 2,
  parameter int DATA_W   = 8,
  parameter int MISS_LAT = 3,   // >= 3: load on the next-to-last edge
  parameter int REF_INT  = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ROW_W+COL_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic                    ready_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    ref_stb_o,
  output logic [ROW_W-1:0]        ref_row_o
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int LINE_W = (1 << COL_W) * DATA_W;
  localparam int CNT_W  = $clog2(MISS_LAT + 1);

  rr_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ROW_W-1:0]  row_in, lat_row_q, held_tag;
  logic [COL_W-1:0]  col_in, lat_col_q, sel_col;
  logic [LINE_W-1:0] arr_line;
  logic [DATA_W-1:0] line_word, rdata_q;
  logic              ready_q, row_hit, held_valid;
  logic              start, wr_en, rd_hit, rd_miss, st_load, load_en, load_done, arr_busy;

  assign row_in    = addr_i[ADDR_W-1:COL_W];
  assign col_in    = addr_i[COL_W-1:0];
  assign st_load   = (state_q == ST_LOAD);
  assign start     = req_i && !ready_q && !st_load;
  assign wr_en     = start && we_i;
  assign rd_hit    = start && !we_i && row_hit;
  assign rd_miss   = start && !we_i && !row_hit;
  assign load_en   = st_load && (cnt_q == CNT_W'(MISS_LAT - 2));
  assign load_done = st_load && (cnt_q == CNT_W'(MISS_LAT - 1));
  assign sel_col   = st_load ? lat_col_q : col_in;
  assign arr_busy  = st_load || wr_en || rd_miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      lat_row_q <= '0;
      lat_col_q <= '0;
      ready_q   <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ready_q <= wr_en || rd_hit || load_done;
      if (rd_hit || load_done) rdata_q <= line_word;
      if (rd_miss) begin
        state_q   <= ST_LOAD;
        cnt_q     <= CNT_W'(1);
        lat_row_q <= row_in;
        lat_col_q <= col_in;
      end else if (st_load) begin
        cnt_q <= cnt_q + 1'b1;
        if (load_done) state_q <= ST_IDLE;
      end
    end
  end

  rowreg_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en),
    .wr_row_i  (row_in),
    .wr_col_i  (col_in),
    .wr_data_i (wdata_i),
    .rd_row_i  (lat_row_q),
    .rd_line_o (arr_line)
  );

  rowreg_line #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_en),
    .load_row_i   (lat_row_q),
    .load_line_i  (arr_line),
    .patch_i      (wr_en && row_hit),
    .patch_col_i  (col_in),
    .patch_data_i (wdata_i),
    .cmp_row_i    (row_in),
    .sel_col_i    (sel_col),
    .hit_o        (row_hit),
    .word_o       (line_word),
    .tag_o        (held_tag),
    .valid_o      (held_valid)
  );

  rowreg_refresh #(.ROW_W(ROW_W), .REF_INT(REF_INT)) u_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (arr_busy),
    .stb_o  (ref_stb_o),
    .row_o  (ref_row_o)
  );

  assign ready_o = ready_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/rowreg_dram_chk.sv
module rowreg_dram_chk #(
  parameter int ROW_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             ready_o,
  input logic             start_i,
  input logic             hit_i,
  input logic             load_busy_i,
  input logic [ROW_W-1:0] tag_i,
  input logic             valid_i,
  input logic             ref_stb_o,
  input logic [ROW_W-1:0] ref_row_o
);
  logic             seen_q;
  logic [ROW_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (ref_stb_o) begin
      seen_q <= 1'b1;
      last_q <= ref_row_o;
    end
  end

  p_valid_via_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(valid_i) || $past(load_busy_i));

  p_hit_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !we_i && hit_i |=> ready_o);

  p_ready_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_miss_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !we_i && !hit_i |=> !ready_o && load_busy_i);

  p_write_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && we_i |=> ready_o);

  p_wmiss_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && we_i && !hit_i |=> $stable(tag_i) && $stable(valid_i));

  p_ref_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_stb_o && seen_q |-> ref_row_o == ROW_W'(last_q + 1'b1));

  p_ref_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_stb_o |=> !ref_stb_o);

  p_ref_defer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_stb_o |-> !$past(load_busy_i) && !$past(start_i && (we_i || !hit_i)));
endmodule

bind rowreg_dram rowreg_dram_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .ready_o     (ready_o),
  .start_i     (start),
  .hit_i       (row_hit),
  .load_busy_i (st_load),
  .tag_i       (held_tag),
  .valid_i     (held_valid),
  .ref_stb_o   (ref_stb_o),
  .ref_row_o   (ref_row_o)
);

// File: tb/rowreg_dram_test.sv
module rowreg_dram_test;
  localparam int ROW_W = 3, COL_W = 2, DATA_W = 8, MISS_LAT = 3, REF_INT = 20;
  localparam int NUM_ROWS = 1 << ROW_W;
  localparam int NWORDS = 1 << (ROW_W + COL_W);

  typedef struct {
    bit     rd;
    bit     miss;
    int     lat;
    int     data;
    string  rq;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [ROW_W+COL_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic ready_o, ref_stb_o;
  logic [DATA_W-1:0] rdata_o;
  logic [ROW_W-1:0] ref_row_o;

  int errors = 0, checks = 0;
  int cyc = 0, lat_cnt = 0;
  int mem [NWORDS];
  int held_row = 0;
  bit held_valid = 1'b0;
  item_t q[$];
  bit busy_prev = 1'b0, idle_mode = 1'b0, prev_idle = 1'b0;
  int exp_ref_row = 0, last_stb = 0, stb_total = 0, idle_stb = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rowreg_dram #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                .MISS_LAT(MISS_LAT), .REF_INT(REF_INT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .ref_stb_o(ref_stb_o), .ref_row_o(ref_row_o));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit w, input int a, input int d, input string rq);
    item_t it;
    int row;
    row = a >> COL_W;
    it.rd = !w; it.rq = rq; it.data = 0; it.miss = 1'b0; it.lat = 1;
    if (w) mem[a] = d & 8'hff;
    else begin
      it.miss = !held_valid || held_row != row;
      it.lat  = it.miss ? MISS_LAT : 1;
      it.data = mem[a];
      held_row = row; held_valid = 1'b1;
    end
    q.push_back(it);
    req_i = 1'b1; we_i = w; addr_i = (ROW_W+COL_W)'(a); wdata_i = DATA_W'(d);
    do @(negedge clk); while (!ready_o);
    @(posedge clk); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_ni) begin
    if (ref_stb_o) begin
      stb_total++;
      chk(!busy_prev, "R9", "refresh strobe after busy edge", 1, 0);
      chk(int'(ref_row_o) == exp_ref_row, "R8", "refresh row", int'(ref_row_o), exp_ref_row);
      exp_ref_row = (exp_ref_row + 1) % NUM_ROWS;
      if (idle_mode) begin
        idle_stb++;
        if (prev_idle) chk(cyc - last_stb == REF_INT, "R8", "refresh spacing", cyc - last_stb, REF_INT);
      end
      prev_idle = idle_mode;
      last_stb = cyc;
    end
    if (req_i && !ready_o) lat_cnt++;
    if (ready_o) begin
      if (q.size() == 0) chk(1'b0, "R2", "unexpected ready", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(lat_cnt == it.lat, it.rq, "latency", lat_cnt, it.lat);
        if (it.rd) chk(int'(rdata_o) == it.data, it.rq, "read data", int'(rdata_o), it.data);
      end
      lat_cnt = 0;
    end
    busy_prev = req_i && !ready_o && (we_i || (q.size() > 0 && q[0].miss));
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) mem[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(ready_o == 1'b0, "R1", "ready after reset", int'(ready_o), 0);
    chk(ref_stb_o == 1'b0, "R1", "strobe after reset", int'(ref_stb_o), 0);
    chk(rdata_o == '0, "R1", "rdata after reset", int'(rdata_o), 0);
    @(posedge clk); #1;
    access(0, 5, 0, "R1");           // first read misses
    access(0, 6, 0, "R4");           // same row, hit
    access(1, 7, 8'hA5, "R5");       // write hit
    access(0, 7, 0, "R6");           // patched register
    access(1, 12, 8'h3C, "R5");      // write miss
    access(0, 4, 0, "R7");           // held row still row 1
    access(0, 12, 0, "R7");          // written row misses
    for (int a = 0; a < NWORDS; a++) access(1, a, (a * 7 + 3), "R5");
    for (int a = 0; a < NWORDS; a++) access(0, a, 0, ((a % 4) == 0) ? "R3" : "R4");
    for (int a = 0; a < NWORDS; a += 5) access(0, a, 0, "R3");
    for (int k = 0; k < 6; k++) access(0, 9, 0, "R2");
    for (int k = 0; k < 40; k++) begin
      int a;
      a = (k * 13 + 1) % NWORDS;
      access(1, a, k * 29 + 17, "R5");
      access(0, a, 0, "R6");
      access(0, (a + 8) % NWORDS, 0, "R3");
      access(1, (a + 16) % NWORDS, k + 90, "R7");
      access(0, (a + 9) % NWORDS, 0, "R2");
    end
    chk(q.size() == 0, "R2", "pending items", q.size(), 0);
    idle_mode = 1'b1;
    repeat (10 * REF_INT + 5) @(posedge clk);
    chk(idle_stb >= 9, "R8", "idle strobe count", idle_stb, 9);
    chk(stb_total > 0, "R9", "deferred refreshes issued", stb_total, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule